// File: doc/BRIEF.md
# Load Base Register Cache

This block supplies the base and index register values of a load during the fetch stage. The key is the load's own instruction address, not a register number. Each entry is tagged with a load PC. It also records which architectural registers the load uses as base and index, and holds a copy of their current values. A lookup that matches an entry returns both values in the same cycle. A register+constant load receives zero on the index output. Loads whose predecode kind marks them as stack-pointer or global-pointer based never touch the array. They take their base from one of two shadow registers and always hit.

A lookup that misses is flagged at once, so the pipeline can fall back to the normal register-read path. If no refill is in flight, the block then runs a three-cycle refill. In the cycle after the miss it asks the integer register file for the two registers. One cycle later it writes the returned values into an invalid entry, or into the least recently used one when all entries are valid. From the third cycle after the miss, the same load hits. Every register write-back is compared against all entries and both shadows. Each matching copy is updated in that cycle, including the values of a refill still in flight.

Top module: `ldbase_cache`

## Requirements
- R1: After reset no load PC hits, and the stack and global shadow values read as zero.
- R2: A lookup of kind 1 (stack) or kind 2 (global) always hits. It returns the stack shadow (kind 1) or the global shadow (kind 2) on lkBase and zero on lkIndex, and never starts a refill.
- R3: A lookup of kind 0 or kind 3 whose PC matches a valid entry hits in the same cycle and returns that entry's base value. lkIndex carries the entry's index value when lkRegReg is 1 and zero when lkRegReg is 0.
- R4: A kind 0 or 3 lookup that matches no entry raises lkMiss in that cycle. If no refill is in flight, rfRdEn is high in the next cycle with the load's base and index register numbers. The values on rfBaseVal and rfIdxVal in the cycle after that are stored, and the same PC hits from the third cycle after the miss.
- R5: A miss that occurs while a refill is in flight is still reported on lkMiss but allocates no entry and requests no register read.
- R6: A write-back updates, for use from the next cycle, every entry whose base or index register equals wbReg. It also updates the stack shadow when wbReg is 29 and the global shadow when wbReg is 28. A lookup in the same cycle as the write-back still sees the old value.
- R7: A write-back to a register of the refill in flight, in the cycle rfRdEn is high or in the following cycle, is what the new entry holds, whatever the register file returned.
- R8: A refill takes an invalid entry if one exists, and otherwise the least recently used entry. Both a hit and a refill make an entry the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| lkValid | input | 1 | Lookup present this cycle |
| lkPc | input | PC_W | Instruction address of the load |
| lkKind | input | 2 | Predecode kind: 0 other, 1 stack, 2 global, 3 other |
| lkRegReg | input | 1 | 1 for register+register addressing |
| lkBaseReg | input | RNUM_W | Base register number, kept for a refill |
| lkIdxReg | input | RNUM_W | Index register number, kept for a refill |
| lkHit | output | 1 | Lookup returned valid values |
| lkMiss | output | 1 | Lookup of kind 0 or 3 found no entry |
| lkBase | output | DATA_W | Base register value |
| lkIndex | output | DATA_W | Index register value, zero unless register+register |
| wbValid | input | 1 | Register file write this cycle |
| wbReg | input | RNUM_W | Register being written |
| wbData | input | DATA_W | Value being written |
| rfRdEn | output | 1 | Refill read request to the register file |
| rfRdBase | output | RNUM_W | Base register to read |
| rfRdIdx | output | RNUM_W | Index register to read |
| rfBaseVal | input | DATA_W | Base value, valid the cycle after rfRdEn |
| rfIdxVal | input | DATA_W | Index value, valid the cycle after rfRdEn |

## Verification
The assertions assume that the register file answers every rfRdEn with data in exactly the following cycle. They also assume at most one write-back per cycle, and that the base and index register numbers given with a missing lookup are the ones the load really uses. The bench drives rfBaseVal and rfIdxVal only in the cycle after it sees rfRdEn, and issues one write-back at a time. When it tests write-back capture, it returns deliberately stale register file data, so that only the snooping path can produce the expected value.

// File: rtl/ldbase_pkg.sv
package ldbase_pkg;

  // predecode kind of a load
  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_STACK  = 2'd1,
    KIND_GLOBAL = 2'd2,
    KIND_SPARE  = 2'd3
  } ldKind_e;

  // refill sequencer position
  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_READ  = 2'd1,
    FILL_WRITE = 2'd2
  } fillStage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the missing load's PC and registers
    logic readCycle;  // register file read requested this cycle
    logic fillWe;     // write the refill into the victim entry
  } fillCtl_t;

endpackage

// File: rtl/ldbase_ctrl.sv
module ldbase_ctrl
  import ldbase_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arrayLookup,
  input  logic              hitAny,
  input  logic [SLOT_W-1:0] hitSlot,
  input  logic [DEPTH-1:0]  validVec,
  output fillCtl_t          ctl,
  output logic [SLOT_W-1:0] fillSlot
);

  fillStage_e stage, stageNext;
  logic [SLOT_W-1:0] age [DEPTH];
  logic [SLOT_W-1:0] ageHit [DEPTH];
  logic [SLOT_W-1:0] ageNext [DEPTH];
  logic [SLOT_W-1:0] victim;
  logic              freeFound;
  logic              missNow;

  assign missNow = arrayLookup && !hitAny;

  // refill sequencer
  always_comb begin
    stageNext = stage;
    unique case (stage)
      FILL_IDLE:  if (missNow) stageNext = FILL_READ;
      FILL_READ:  stageNext = FILL_WRITE;
      FILL_WRITE: stageNext = FILL_IDLE;
      default:    stageNext = FILL_IDLE;
    endcase
  end

  assign ctl.capture   = missNow && (stage == FILL_IDLE);
  assign ctl.readCycle = (stage == FILL_READ);
  assign ctl.fillWe    = (stage == FILL_WRITE);
  assign fillSlot      = victim;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= FILL_IDLE;
    else        stage <= stageNext;
  end

  // recency ages: 0 is newest, DEPTH-1 oldest; always a permutation
  always_comb begin
    ageHit = age;
    if (arrayLookup && hitAny) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (SLOT_W'(j) == hitSlot)      ageHit[j] = '0;
        else if (age[j] < age[hitSlot]) ageHit[j] = age[j] + 1'b1;
      end
    end

    victim    = '0;
    freeFound = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (!validVec[j] && !freeFound) begin
        victim    = SLOT_W'(j);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (ageHit[j] == SLOT_W'(DEPTH - 1)) victim = SLOT_W'(j);
      end
    end

    ageNext = ageHit;
    if (ctl.fillWe) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (SLOT_W'(j) == victim)             ageNext[j] = '0;
        else if (ageHit[j] < ageHit[victim])  ageNext[j] = ageHit[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) age[j] <= SLOT_W'(j);
    end else begin
      age <= ageNext;
    end
  end

  logic [DEPTH-1:0] ageSeen;
  always_comb begin
    ageSeen = '0;
    for (int j = 0; j < DEPTH; j++) ageSeen[age[j]] = 1'b1;
  end

  // R8
  age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &ageSeen);

  // R4
  fill_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.readCycle |=> ctl.fillWe);

  // R5
  read_from_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.readCycle) |-> $past(arrayLookup && !hitAny));

endmodule

// File: rtl/ldbase_datapath.sv
module ldbase_datapath
  import ldbase_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int RNUM_W = 5,
  parameter int SP_REG = 29,
  parameter int GP_REG = 28,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic [PC_W-1:0]   lkPc,
  input  ldKind_e           lkKind,
  input  logic              lkRegReg,
  input  logic [RNUM_W-1:0] lkBaseReg,
  input  logic [RNUM_W-1:0] lkIdxReg,
  input  logic              wbValid,
  input  logic [RNUM_W-1:0] wbReg,
  input  logic [DATA_W-1:0] wbData,
  input  logic [DATA_W-1:0] rfBaseVal,
  input  logic [DATA_W-1:0] rfIdxVal,
  input  fillCtl_t          ctl,
  input  logic [SLOT_W-1:0] fillSlot,
  output logic              arrayLookup,
  output logic              hitAny,
  output logic [SLOT_W-1:0] hitSlot,
  output logic [DEPTH-1:0]  validVec,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [DATA_W-1:0] lkBase,
  output logic [DATA_W-1:0] lkIndex,
  output logic              rfRdEn,
  output logic [RNUM_W-1:0] rfRdBase,
  output logic [RNUM_W-1:0] rfRdIdx
);

  localparam logic [RNUM_W-1:0] SP_NUM = RNUM_W'(SP_REG);
  localparam logic [RNUM_W-1:0] GP_NUM = RNUM_W'(GP_REG);

  logic [PC_W-1:0]   tagPc   [DEPTH];
  logic [RNUM_W-1:0] baseReg [DEPTH];
  logic [RNUM_W-1:0] idxReg  [DEPTH];
  logic [DATA_W-1:0] baseVal [DEPTH];
  logic [DATA_W-1:0] idxVal  [DEPTH];
  logic [DATA_W-1:0] spVal, gpVal;

  // refill in flight
  logic [PC_W-1:0]   pPc;
  logic [RNUM_W-1:0] pBase, pIdx;
  logic              pBaseOvr, pIdxOvr;
  logic [DATA_W-1:0] pBaseHeld, pIdxHeld;
  logic [DATA_W-1:0] fillBase, fillIdx;

  logic [DEPTH-1:0] hitVec;
  logic shadowKind;

  assign shadowKind  = (lkKind == KIND_STACK) || (lkKind == KIND_GLOBAL);
  assign arrayLookup = lkValid && !shadowKind;

  always_comb begin
    hitSlot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hitVec[i] = validVec[i] && (tagPc[i] == lkPc);
      if (hitVec[i]) hitSlot = hitSlot | SLOT_W'(i);
    end
  end
  assign hitAny = |hitVec;

  assign lkHit  = lkValid && (shadowKind || hitAny);
  assign lkMiss = arrayLookup && !hitAny;

  always_comb begin
    if (lkKind == KIND_STACK)       lkBase = spVal;
    else if (lkKind == KIND_GLOBAL) lkBase = gpVal;
    else if (hitAny)                lkBase = baseVal[hitSlot];
    else                            lkBase = '0;
    lkIndex = (!shadowKind && lkRegReg && hitAny) ? idxVal[hitSlot] : '0;
  end

  assign rfRdEn   = ctl.readCycle;
  assign rfRdBase = pBase;
  assign rfRdIdx  = pIdx;

  // newest value wins: this cycle's write-back, then a snooped one, then the register file
  assign fillBase = (wbValid && wbReg == pBase) ? wbData : (pBaseOvr ? pBaseHeld : rfBaseVal);
  assign fillIdx  = (wbValid && wbReg == pIdx)  ? wbData : (pIdxOvr  ? pIdxHeld  : rfIdxVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        validVec[i] <= 1'b0;
        tagPc[i]    <= '0;
        baseReg[i]  <= '0;
        idxReg[i]   <= '0;
        baseVal[i]  <= '0;
        idxVal[i]   <= '0;
      end
      spVal     <= '0;
      gpVal     <= '0;
      pPc       <= '0;
      pBase     <= '0;
      pIdx      <= '0;
      pBaseOvr  <= 1'b0;
      pIdxOvr   <= 1'b0;
      pBaseHeld <= '0;
      pIdxHeld  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctl.fillWe && fillSlot == SLOT_W'(i)) begin
          validVec[i] <= 1'b1;
          tagPc[i]    <= pPc;
          baseReg[i]  <= pBase;
          idxReg[i]   <= pIdx;
          baseVal[i]  <= fillBase;
          idxVal[i]   <= fillIdx;
        end else if (wbValid) begin
          if (baseReg[i] == wbReg) baseVal[i] <= wbData;
          if (idxReg[i] == wbReg)  idxVal[i]  <= wbData;
        end
      end
      if (wbValid && wbReg == SP_NUM) spVal <= wbData;
      if (wbValid && wbReg == GP_NUM) gpVal <= wbData;

      if (ctl.capture) begin
        pPc      <= lkPc;
        pBase    <= lkBaseReg;
        pIdx     <= lkIdxReg;
        pBaseOvr <= 1'b0;
        pIdxOvr  <= 1'b0;
      end else begin
        if (wbValid && wbReg == pBase) begin
          pBaseOvr  <= 1'b1;
          pBaseHeld <= wbData;
        end
        if (wbValid && wbReg == pIdx) begin
          pIdxOvr  <= 1'b1;
          pIdxHeld <= wbData;
        end
      end
    end
  end

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hitVec));

  // R6
  sp_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && wbReg == SP_NUM) |=> (spVal == $past(wbData)));

  // R4
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.fillWe |=> validVec[$past(fillSlot)]);

  // R7
  fill_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fillWe && wbValid && wbReg == pBase) |=> (baseVal[$past(fillSlot)] == $past(wbData)));

endmodule

// File: rtl/ldbase_cache.sv
module ldbase_cache
  import ldbase_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int RNUM_W = 5,
  parameter int SP_REG = 29,
  parameter int GP_REG = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [1:0]        lkKind,
  input  logic              lkRegReg,
  input  logic [RNUM_W-1:0] lkBaseReg,
  input  logic [RNUM_W-1:0] lkIdxReg,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [DATA_W-1:0] lkBase,
  output logic [DATA_W-1:0] lkIndex,
  input  logic              wbValid,
  input  logic [RNUM_W-1:0] wbReg,
  input  logic [DATA_W-1:0] wbData,
  output logic              rfRdEn,
  output logic [RNUM_W-1:0] rfRdBase,
  output logic [RNUM_W-1:0] rfRdIdx,
  input  logic [DATA_W-1:0] rfBaseVal,
  input  logic [DATA_W-1:0] rfIdxVal
);

  localparam int SLOT_W = $clog2(DEPTH);

  fillCtl_t          ctl;
  logic [SLOT_W-1:0] fillSlot, hitSlot;
  logic [DEPTH-1:0]  validVec;
  logic              arrayLookup, hitAny;

  ldbase_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .arrayLookup(arrayLookup), .hitAny(hitAny), .hitSlot(hitSlot),
    .validVec(validVec), .ctl(ctl), .fillSlot(fillSlot)
  );

  ldbase_datapath #(
    .DEPTH(DEPTH), .PC_W(PC_W), .DATA_W(DATA_W), .RNUM_W(RNUM_W),
    .SP_REG(SP_REG), .GP_REG(GP_REG)
  ) uData (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkPc(lkPc), .lkKind(ldKind_e'(lkKind)), .lkRegReg(lkRegReg),
    .lkBaseReg(lkBaseReg), .lkIdxReg(lkIdxReg),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .rfBaseVal(rfBaseVal), .rfIdxVal(rfIdxVal),
    .ctl(ctl), .fillSlot(fillSlot),
    .arrayLookup(arrayLookup), .hitAny(hitAny), .hitSlot(hitSlot), .validVec(validVec),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkBase(lkBase), .lkIndex(lkIndex),
    .rfRdEn(rfRdEn), .rfRdBase(rfRdBase), .rfRdIdx(rfRdIdx)
  );

endmodule

// File: tb/ldbase_cache_test.sv
module ldbase_cache_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkValid, lkRegReg;
  logic [31:0] lkPc;
  logic [1:0]  lkKind;
  logic [4:0]  lkBaseReg, lkIdxReg;
  logic        lkHit, lkMiss;
  logic [31:0] lkBase, lkIndex;
  logic        wbValid;
  logic [4:0]  wbReg;
  logic [31:0] wbData;
  logic        rfRdEn;
  logic [4:0]  rfRdBase, rfRdIdx;
  logic [31:0] rfBaseVal, rfIdxVal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ldbase_cache #(.DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkPc(lkPc), .lkKind(lkKind), .lkRegReg(lkRegReg),
    .lkBaseReg(lkBaseReg), .lkIdxReg(lkIdxReg),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkBase(lkBase), .lkIndex(lkIndex),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .rfRdEn(rfRdEn), .rfRdBase(rfRdBase), .rfRdIdx(rfRdIdx),
    .rfBaseVal(rfBaseVal), .rfIdxVal(rfIdxVal)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // next cycle, all inputs quiet
  task automatic nextCyc();
    @(negedge clk);
    lkValid = 1'b0; lkPc = '0; lkKind = 2'd0; lkRegReg = 1'b0;
    lkBaseReg = '0; lkIdxReg = '0;
    wbValid = 1'b0; wbReg = '0; wbData = '0;
    rfBaseVal = '0; rfIdxVal = '0;
  endtask

  task automatic look(input logic [31:0] pc, input logic [1:0] kind, input logic rr,
                      input logic [4:0] b, input logic [4:0] i);
    lkValid = 1'b1; lkPc = pc; lkKind = kind; lkRegReg = rr; lkBaseReg = b; lkIdxReg = i;
  endtask

  task automatic wb(input logic [4:0] r, input logic [31:0] d);
    wbValid = 1'b1; wbReg = r; wbData = d;
  endtask

  // full miss and refill sequence, then a confirming hit
  task automatic doFill(input logic [31:0] pc, input logic [4:0] b, input logic [4:0] i,
                        input logic [31:0] bv, input logic [31:0] iv);
    nextCyc(); look(pc, 2'd0, 1'b0, b, i); #1;
    chkEq("R4 miss flagged", {31'd0, lkMiss}, 32'd1);
    chkEq("R4 no hit on miss", {31'd0, lkHit}, 32'd0);
    nextCyc(); #1;
    chkEq("R4 read request", {31'd0, rfRdEn}, 32'd1);
    chkEq("R4 read base reg", {27'd0, rfRdBase}, {27'd0, b});
    chkEq("R4 read idx reg", {27'd0, rfRdIdx}, {27'd0, i});
    nextCyc(); rfBaseVal = bv; rfIdxVal = iv; #1;
    chkEq("R4 single request", {31'd0, rfRdEn}, 32'd0);
    nextCyc(); look(pc, 2'd0, 1'b1, b, i); #1;
    chkEq("R4 hit after refill", {31'd0, lkHit}, 32'd1);
    chkEq("R4 base after refill", lkBase, bv);
    chkEq("R4 index after refill", lkIndex, iv);
  endtask

  task automatic expectHit(input string tag, input logic [31:0] pc, input logic [31:0] bv);
    nextCyc(); look(pc, 2'd0, 1'b0, 5'd0, 5'd0); #1;
    chkEq({tag, " hit"}, {31'd0, lkHit}, 32'd1);
    chkEq({tag, " base"}, lkBase, bv);
  endtask

  task automatic testReset();
    nextCyc(); look(32'h40, 2'd0, 1'b0, 5'd1, 5'd2); #1;
    chkEq("R1 empty after reset", {31'd0, lkHit}, 32'd0);
    nextCyc(); #1; // let the refill request drain
    nextCyc(); #1;
    nextCyc(); look(32'h0, 2'd1, 1'b0, 5'd0, 5'd0); #1;
    chkEq("R1 stack shadow zero", lkBase, 32'd0);
    nextCyc(); look(32'h0, 2'd2, 1'b0, 5'd0, 5'd0); #1;
    chkEq("R1 global shadow zero", lkBase, 32'd0);
  endtask

  task automatic testShadows();
    nextCyc(); wb(5'd29, 32'h0000_5A00); look(32'h80, 2'd1, 1'b1, 5'd29, 5'd3); #1;
    chkEq("R6 same-cycle old stack", lkBase, 32'd0);
    nextCyc(); look(32'h84, 2'd1, 1'b1, 5'd29, 5'd3); #1;
    chkEq("R2 stack hit", {31'd0, lkHit}, 32'd1);
    chkEq("R2 stack base", lkBase, 32'h0000_5A00);
    chkEq("R2 stack index zero", lkIndex, 32'd0);
    chkEq("R2 no miss", {31'd0, lkMiss}, 32'd0);
    nextCyc(); wb(5'd28, 32'h1000_8000); #1;
    chkEq("R2 no refill request", {31'd0, rfRdEn}, 32'd0);
    nextCyc(); look(32'h88, 2'd2, 1'b0, 5'd28, 5'd0); #1;
    chkEq("R2 global base", lkBase, 32'h1000_8000);
    chkEq("R2 global hit", {31'd0, lkHit}, 32'd1);
  endtask

  task automatic testLru();
    for (int k = 0; k < 8; k++)
      doFill(32'h100 + 32'(k) * 4, 5'd1, 5'd2, 32'hA0 + 32'(k), 32'hB0);
    expectHit("R8 touch oldest", 32'h100, 32'hA0);       // P1 becomes oldest
    doFill(32'h200, 5'd3, 5'd4, 32'hC8, 32'hD8);            // evicts P1
    expectHit("R8 touched entry kept", 32'h100, 32'hA0);
    expectHit("R8 new entry kept", 32'h200, 32'hC8);
    doFill(32'h104, 5'd1, 5'd2, 32'hE1, 32'hF1);            // miss proves P1 gone; evicts P2
    doFill(32'h108, 5'd1, 5'd2, 32'hE2, 32'hF2);            // miss proves P2 gone
    expectHit("R8 younger entry kept", 32'h110, 32'hA4);
  endtask

  task automatic testMulticast();
    doFill(32'h300, 5'd5, 5'd7, 32'h11, 32'h12);
    doFill(32'h304, 5'd9, 5'd5, 32'h21, 32'h22);
    nextCyc(); wb(5'd5, 32'hCAFE_0005); look(32'h300, 2'd0, 1'b1, 5'd5, 5'd7); #1;
    chkEq("R6 same-cycle old value", lkBase, 32'h11);
    nextCyc(); look(32'h300, 2'd0, 1'b1, 5'd5, 5'd7); #1;
    chkEq("R6 base copy updated", lkBase, 32'hCAFE_0005);
    nextCyc(); look(32'h304, 2'd0, 1'b1, 5'd9, 5'd5); #1;
    chkEq("R6 index copy updated", lkIndex, 32'hCAFE_0005);
    chkEq("R6 other base untouched", lkBase, 32'h21);
    nextCyc(); look(32'h304, 2'd0, 1'b0, 5'd9, 5'd5); #1;
    chkEq("R3 const mode index zero", lkIndex, 32'd0);
    nextCyc(); look(32'h304, 2'd3, 1'b1, 5'd9, 5'd5); #1;
    chkEq("R3 kind 3 hit", {31'd0, lkHit}, 32'd1);
    chkEq("R3 kind 3 index", lkIndex, 32'hCAFE_0005);
  endtask

  task automatic testBusy();
    nextCyc(); look(32'h400, 2'd0, 1'b0, 5'd12, 5'd13); #1;
    chkEq("R5 first miss", {31'd0, lkMiss}, 32'd1);
    nextCyc(); look(32'h500, 2'd0, 1'b0, 5'd14, 5'd15); #1;
    chkEq("R5 busy miss reported", {31'd0, lkMiss}, 32'd1);
    chkEq("R5 request is first load", {27'd0, rfRdBase}, 32'd12);
    nextCyc(); look(32'h500, 2'd0, 1'b0, 5'd14, 5'd15); rfBaseVal = 32'h77; rfIdxVal = 32'h78; #1;
    chkEq("R5 no request while writing", {31'd0, rfRdEn}, 32'd0);
    nextCyc(); look(32'h400, 2'd0, 1'b1, 5'd12, 5'd13); #1;
    chkEq("R5 first load filled", lkBase, 32'h77);
    doFill(32'h500, 5'd14, 5'd15, 32'h99, 32'h9A);          // still a miss: not allocated
  endtask

  task automatic testSnoop();
    nextCyc(); look(32'h600, 2'd0, 1'b1, 5'd10, 5'd11); #1;
    chkEq("R7 miss", {31'd0, lkMiss}, 32'd1);
    nextCyc(); wb(5'd11, 32'hAAAA_0011); #1;
    chkEq("R7 request", {31'd0, rfRdEn}, 32'd1);
    nextCyc(); wb(5'd10, 32'hBBBB_0010); rfBaseVal = 32'h111; rfIdxVal = 32'h222; #1;
    nextCyc(); look(32'h600, 2'd0, 1'b1, 5'd10, 5'd11); #1;
    chkEq("R7 base from write-back", lkBase, 32'hBBBB_0010);
    chkEq("R7 index from write-back", lkIndex, 32'hAAAA_0011);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lkValid = 1'b0; lkPc = '0; lkKind = 2'd0; lkRegReg = 1'b0;
    lkBaseReg = '0; lkIdxReg = '0;
    wbValid = 1'b0; wbReg = '0; wbData = '0;
    rfBaseVal = '0; rfIdxVal = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testShadows();
    testLru();
    testMulticast();
    testBusy();
    testSnoop();
    nextCyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule